// File: doc/BRIEF.md
# Packed SIMD Immediate Saturation Unit

This unit executes one family of vector instructions: lane-wise saturation of a 128-bit source vector to a range set by an immediate bit count. It decodes a 32-bit instruction word. That word selects signed or unsigned treatment, one of four lane widths (8, 16, 32 or 64 bits) and the immediate. The unit then clamps every lane of the source vector independently and returns the clamped vector. It also returns the destination and source register indices carried in the word, and a flag that says whether the word was recognised.

Signed forms keep each lane inside [-2^n, 2^n - 1], where n is the immediate. The lower limit is the bitwise complement of the upper one. Unsigned forms cap each lane at 2^(n+1) - 1 and have no lower limit. When n + 1 equals the lane width, the cap is all ones and the lane passes through unchanged.

The result leaves through one register stage by default, so outputs follow the inputs by one clock. A parameter removes that stage and makes the unit purely combinational.

Top module: `sat_vec_unit`

## Requirements
- R1: A word whose bits [31:20] differ from 0111_0011_0010, or whose bits [18:13] match none of the four lane patterns, clears the recognised flag. It also drives the result vector and both register indices to zero.
- R2: Bit 19 selects signed (0) or unsigned (1). The lane width is decoded as follows:
  - bits [18:13] = 000001 gives 8-bit lanes, with the immediate in bits [12:10];
  - bits [18:14] = 00001 gives 16-bit lanes, with the immediate in bits [13:10];
  - bits [18:15] = 0001 gives 32-bit lanes, with the immediate in bits [14:10];
  - bits [18:16] = 001 gives 64-bit lanes, with the immediate in bits [15:10].
- R3: For a recognised word, the destination index output equals bits [4:0] and the source index output equals bits [9:5].
- R4: In signed forms, a lane greater than 2^n - 1 (signed compare) becomes 2^n - 1.
- R5: In signed forms, a lane below the complement of the upper limit, which is -2^n, becomes that lower limit.
- R6: In signed forms, a lane between the two limits, the limits themselves included, is returned unchanged.
- R7: In unsigned forms, a lane above 2^(n+1) - 1 (unsigned compare) becomes that value. Smaller lanes, zero included, are unchanged.
- R8: In unsigned forms with n equal to the lane width minus one, every lane is returned unchanged, since the cap is all ones.
- R9: Lane i occupies bits [i*W+W-1 : i*W]. Each lane is clamped independently of its neighbours: 16, 8, 4 or 2 lanes respectively.
- R10: With the output stage enabled, outputs show the word and vector presented at the previous rising clock edge. An active-low asynchronous reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output stage |
| rst_ni | input | 1 | Asynchronous active-low reset |
| insn_i | input | 32 | Instruction word |
| src_i | input | VEC_W (128) | Source vector |
| hit_o | output | 1 | Word recognised as a saturate operation |
| rd_o | output | 5 | Destination register index |
| rs_o | output | 5 | Source register index |
| vec_o | output | VEC_W (128) | Saturated result vector |

## Verification
Some checks run on every lane of every width on every cycle: each result stays inside its limits, and an in-range signed lane passes through untouched. The clocked checks confirm that at most one lane-width pattern matches. They also confirm that a miss clears the outputs and that the register indices follow the previous word. Whether the limits are the right ones for a given immediate needs the bench's scenarios against its reference model: the off-by-one between the signed and unsigned limits, the all-ones unsigned cap, and the lane placement. Those scenarios cover both extreme immediates per width, the most negative and most positive lanes, and lanes exactly at each limit.

// File: rtl/sat_pkg.sv
package sat_pkg;

   localparam logic [11:0] SAT_MAJOR = 12'b0111_0011_0010;
   localparam int          NUM_SZ    = 4;
   localparam int          IMM_MAX_W = 6;

   typedef enum logic [1:0] {
      LSZ_8  = 2'd0,
      LSZ_16 = 2'd1,
      LSZ_32 = 2'd2,
      LSZ_64 = 2'd3
   } lane_sz_e;

   typedef struct packed {
      logic                 hit;
      logic                 uns;
      lane_sz_e             sz;
      logic [IMM_MAX_W-1:0] imm;
      logic [4:0]           rd;
      logic [4:0]           rs;
   } sat_op_t;

endpackage

// File: rtl/sat_decode.sv
module sat_decode
   import sat_pkg::*;
(
   input  logic [31:0]       insn_i,
   output sat_op_t           op_o,
   output logic [NUM_SZ-1:0] match_o
);

   logic major;

   always_comb begin
      major      = (insn_i[31:20] == SAT_MAJOR);
      match_o[0] = major && (insn_i[18:13] == 6'b000001);
      match_o[1] = major && (insn_i[18:14] == 5'b00001);
      match_o[2] = major && (insn_i[18:15] == 4'b0001);
      match_o[3] = major && (insn_i[18:16] == 3'b001);
   end

   always_comb begin
      op_o     = '0;
      op_o.hit = |match_o;
      if (op_o.hit) begin
         op_o.uns = insn_i[19];
         op_o.rd  = insn_i[4:0];
         op_o.rs  = insn_i[9:5];
         unique case (1'b1)
            match_o[0]: begin op_o.sz = LSZ_8;  op_o.imm = {3'b000, insn_i[12:10]}; end
            match_o[1]: begin op_o.sz = LSZ_16; op_o.imm = {2'b00,  insn_i[13:10]}; end
            match_o[2]: begin op_o.sz = LSZ_32; op_o.imm = {1'b0,   insn_i[14:10]}; end
            default:    begin op_o.sz = LSZ_64; op_o.imm = insn_i[15:10];           end
         endcase
      end
   end

endmodule

// File: rtl/sat_bound.sv
module sat_bound #(
   parameter int W  = 8,
   localparam int IW = $clog2(W)
) (
   input  logic          uns_i,
   input  logic [IW-1:0] imm_i,
   output logic [W-1:0]  hi_o,
   output logic [W-1:0]  lo_o
);

   localparam logic [W:0] ONE = 1;

   logic [IW:0] shamt;
   logic [W:0]  pow;
   logic [W:0]  lim;

   if (W < 8 || (W & (W - 1)) != 0) begin : g_bad_w
      $error("sat_bound: W must be a power of two, at least 8");
   end

   always_comb begin
      // unsigned cap carries one more bit than the signed limit
      shamt = uns_i ? ({1'b0, imm_i} + 1'b1) : {1'b0, imm_i};
      pow   = ONE << shamt;
      lim   = pow - ONE;
      hi_o  = lim[W-1:0];
      lo_o  = ~lim[W-1:0];
   end

endmodule

// File: rtl/sat_lane.sv
module sat_lane #(
   parameter int W = 8
) (
   input  logic         uns_i,
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] hi_i,
   input  logic [W-1:0] lo_i,
   output logic [W-1:0] y_o
);

   logic [W-1:0] raised;

   always_comb begin
      if (uns_i) begin
         raised = x_i;
         y_o    = (x_i > hi_i) ? hi_i : x_i;
      end else begin
         raised = ($signed(x_i) < $signed(lo_i)) ? lo_i : x_i;
         y_o    = ($signed(raised) > $signed(hi_i)) ? hi_i : raised;
      end
   end

   always_comb begin
      if (uns_i) begin
         AST_U_CEIL: assert (y_o <= hi_i) else $error("unsigned lane above cap");  // R7
      end else begin
         AST_S_CEIL: assert ($signed(y_o) <= $signed(hi_i)) else $error("signed lane above limit");  // R4
         AST_S_FLOOR: assert ($signed(y_o) >= $signed(lo_i)) else $error("signed lane below limit");  // R5
         if ($signed(x_i) >= $signed(lo_i) && $signed(x_i) <= $signed(hi_i)) begin
            AST_S_KEEP: assert (y_o == x_i) else $error("in-range lane altered");  // R6
         end
      end
   end

endmodule

// File: rtl/sat_vec_unit.sv
module sat_vec_unit
   import sat_pkg::*;
#(
   parameter int VEC_W   = 128,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [31:0]      insn_i,
   input  logic [VEC_W-1:0] src_i,
   output logic             hit_o,
   output logic [4:0]       rd_o,
   output logic [4:0]       rs_o,
   output logic [VEC_W-1:0] vec_o
);

   if (VEC_W < 64 || (VEC_W % 64) != 0) begin : g_bad_vec
      $error("sat_vec_unit: VEC_W must be a positive multiple of 64");
   end

   sat_op_t                      op;
   logic [NUM_SZ-1:0]            match;
   logic [NUM_SZ-1:0][VEC_W-1:0] res_by_sz;
   logic [VEC_W-1:0]             vec_c;

   sat_decode u_dec (
      .insn_i  (insn_i),
      .op_o    (op),
      .match_o (match)
   );

   for (genvar k = 0; k < NUM_SZ; k++) begin : g_sz
      localparam int W  = 8 << k;
      localparam int IW = $clog2(W);
      localparam int NL = VEC_W / W;

      logic [W-1:0] hi;
      logic [W-1:0] lo;

      sat_bound #(.W(W)) u_bound (
         .uns_i (op.uns),
         .imm_i (op.imm[IW-1:0]),
         .hi_o  (hi),
         .lo_o  (lo)
      );

      for (genvar j = 0; j < NL; j++) begin : g_lane
         logic [W-1:0] y;
         sat_lane #(.W(W)) u_lane (
            .uns_i (op.uns),
            .x_i   (src_i[j*W +: W]),
            .hi_i  (hi),
            .lo_i  (lo),
            .y_o   (y)
         );
         assign res_by_sz[k][j*W +: W] = y;
      end
   end

   assign vec_c = op.hit ? res_by_sz[op.sz] : '0;

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            hit_o <= 1'b0;
            rd_o  <= '0;
            rs_o  <= '0;
            vec_o <= '0;
         end else begin
            hit_o <= op.hit;
            rd_o  <= op.rd;
            rs_o  <= op.rs;
            vec_o <= vec_c;
         end
      end

      AST_MISS_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !hit_o |-> (vec_o == '0 && rd_o == '0 && rs_o == '0)) else $error("miss left data");  // R1
      AST_SIZE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $onehot0(match)) else $error("several lane widths matched");  // R2
      AST_IDX_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ($past(rst_ni) && $past(insn_i[31:20]) == SAT_MAJOR && $past(match) != '0)
         |-> (rd_o == $past(insn_i[4:0]) && rs_o == $past(insn_i[9:5])))
         else $error("register index mismatch");  // R3
   end else begin : g_comb
      assign hit_o = op.hit;
      assign rd_o  = op.rd;
      assign rs_o  = op.rs;
      assign vec_o = vec_c;
   end

endmodule

// File: tb/sat_vec_unit_test.sv
module sat_vec_unit_test;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [31:0]  insn = '0;
   logic [127:0] src = '0;
   logic         hit;
   logic [4:0]   rd, rs;
   logic [127:0] vec;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   sat_vec_unit #(.VEC_W(128), .OUT_REG(1'b1)) uut (
      .clk_i(clk), .rst_ni(rst_n), .insn_i(insn), .src_i(src),
      .hit_o(hit), .rd_o(rd), .rs_o(rs), .vec_o(vec)
   );

   typedef struct packed {
      logic         raw;
      logic [31:0]  rinsn;
      logic         u;
      logic [1:0]   sz;
      logic [5:0]   imm;
      logic [4:0]   rd;
      logic [4:0]   rs;
      logic [127:0] src;
   } ent_t;

   localparam logic [127:0] SX8   = 128'h807F00FF01FE7E8140C007F808F710F0;
   localparam logic [127:0] SX16  = 128'h80007FFF0000FFFF007FFF800080FF7F;
   localparam logic [127:0] SX32  = 128'h800000007FFFFFFF00000FFFFFFFF000;
   localparam logic [127:0] SX64  = 128'h80000000000000007FFFFFFFFFFFFFFF;
   localparam logic [127:0] SX64B = 128'h000000FFFFFFFFFFFFFFFF0000000000;
   localparam logic [127:0] SMIX  = 128'h0123456789ABCDEFFEDCBA9876543210;
   localparam logic [31:0]  Z32   = 32'h0;

   localparam int N = 26;
   localparam ent_t TBL [N] = '{
      '{1'b0, Z32, 1'b0, 2'd0, 6'd0,  5'd1,  5'd2,  SX8},    // R4 R5 s8 min imm
      '{1'b0, Z32, 1'b0, 2'd0, 6'd7,  5'd3,  5'd4,  SX8},    // R6 s8 max imm
      '{1'b0, Z32, 1'b0, 2'd0, 6'd3,  5'd5,  5'd6,  SX8},    // R4 R5 R6 at bounds
      '{1'b0, Z32, 1'b1, 2'd0, 6'd0,  5'd7,  5'd8,  SX8},    // R7
      '{1'b0, Z32, 1'b1, 2'd0, 6'd7,  5'd9,  5'd10, SX8},    // R8
      '{1'b0, Z32, 1'b1, 2'd0, 6'd3,  5'd11, 5'd12, SX8},    // R7 at bound
      '{1'b0, Z32, 1'b0, 2'd1, 6'd0,  5'd13, 5'd14, SX16},
      '{1'b0, Z32, 1'b0, 2'd1, 6'd15, 5'd15, 5'd16, SX16},
      '{1'b0, Z32, 1'b0, 2'd1, 6'd7,  5'd17, 5'd18, SX16},
      '{1'b0, Z32, 1'b1, 2'd1, 6'd15, 5'd19, 5'd20, SX16},
      '{1'b0, Z32, 1'b1, 2'd1, 6'd6,  5'd21, 5'd22, SX16},
      '{1'b0, Z32, 1'b0, 2'd2, 6'd0,  5'd23, 5'd24, SX32},
      '{1'b0, Z32, 1'b0, 2'd2, 6'd31, 5'd25, 5'd26, SX32},
      '{1'b0, Z32, 1'b0, 2'd2, 6'd12, 5'd27, 5'd28, SX32},
      '{1'b0, Z32, 1'b1, 2'd2, 6'd31, 5'd29, 5'd30, SX32},
      '{1'b0, Z32, 1'b1, 2'd2, 6'd11, 5'd31, 5'd0,  SX32},
      '{1'b0, Z32, 1'b0, 2'd3, 6'd0,  5'd1,  5'd31, SX64},
      '{1'b0, Z32, 1'b0, 2'd3, 6'd63, 5'd2,  5'd30, SX64},
      '{1'b0, Z32, 1'b0, 2'd3, 6'd40, 5'd3,  5'd29, SX64B},
      '{1'b0, Z32, 1'b1, 2'd3, 6'd63, 5'd4,  5'd28, SX64},
      '{1'b0, Z32, 1'b1, 2'd3, 6'd0,  5'd5,  5'd27, SMIX},
      '{1'b0, Z32, 1'b1, 2'd3, 6'd39, 5'd6,  5'd26, SX64B},
      '{1'b0, Z32, 1'b0, 2'd0, 6'd5,  5'd7,  5'd25, SMIX},   // R9 mixed lanes
      '{1'b1, {12'h733, 1'b0, 6'b000001, 13'h0ABC}, 1'b0, 2'd0, 6'd0, 5'd0, 5'd0, SX8},  // R1 major
      '{1'b1, {12'h732, 1'b0, 6'b000000, 13'h1ABC}, 1'b0, 2'd0, 6'd0, 5'd0, 5'd0, SX8},  // R1 size
      '{1'b1, {12'h732, 1'b1, 3'b010, 16'h0155},    1'b0, 2'd0, 6'd0, 5'd0, 5'd0, SX16}  // R1 hole
   };

   function automatic logic [31:0] mk(logic u, logic [1:0] sz, logic [5:0] imm,
                                      logic [4:0] d, logic [4:0] s);
      logic [31:0] w;
      w        = '0;
      w[31:20] = 12'b0111_0011_0010;
      w[19]    = u;
      case (sz)
         2'd0: begin w[18:13] = 6'b000001; w[12:10] = imm[2:0]; end
         2'd1: begin w[18:14] = 5'b00001;  w[13:10] = imm[3:0]; end
         2'd2: begin w[18:15] = 4'b0001;   w[14:10] = imm[4:0]; end
         default: begin w[18:16] = 3'b001; w[15:10] = imm[5:0]; end
      endcase
      w[9:5] = s;
      w[4:0] = d;
      return w;
   endfunction

   function automatic logic [127:0] ref_sat(logic u, logic [1:0] sz, int imm, logic [127:0] s);
      int w;
      logic [63:0]  mask, v, r, cap;
      longint       sv, shi, slo;
      logic [127:0] o;
      w    = 8 << sz;
      mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
      o    = '0;
      for (int l = 0; l < 128 / w; l++) begin
         v = 64'(s >> (l * w)) & mask;
         if (u) begin
            cap = (imm + 1 == 64) ? '1 : ((64'd1 << (imm + 1)) - 64'd1);
            r   = (v > cap) ? cap : v;
         end else begin
            sv  = longint'(v << (64 - w)) >>> (64 - w);
            shi = (64'sd1 <<< imm) - 64'sd1;
            slo = -shi - 64'sd1;
            if (sv < slo) sv = slo;
            if (sv > shi) sv = shi;
            r = 64'(sv);
         end
         o = o | (128'(r & mask) << (l * w));
      end
      return o;
   endfunction

   function automatic string tag(ent_t e);
      if (e.raw) return "R1";
      if (e.u) return (int'(e.imm) == (8 << e.sz) - 1) ? "R8" : "R7";
      return "R4/R5/R6";
   endfunction

   task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog act=timeout exp=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : main
      ent_t e;
      logic [31:0] w;
      logic [127:0] exp_v;

      // R10 reset state
      insn = mk(1'b0, 2'd0, 6'd3, 5'd9, 5'd9);
      src  = SX8;
      repeat (3) @(negedge clk);
      chk("R10 reset hit", 128'(hit), 128'd0);
      chk("R10 reset vec", vec, 128'd0);
      rst_n = 1'b1;

      for (int i = 0; i < N; i++) begin
         e = TBL[i];
         w = e.raw ? e.rinsn : mk(e.u, e.sz, e.imm, e.rd, e.rs);
         @(negedge clk);
         insn = w;
         src  = e.src;
         @(negedge clk);
         exp_v = e.raw ? '0 : ref_sat(e.u, e.sz, int'(e.imm), e.src);
         chk(e.raw ? "R1 flag" : "R2 flag", 128'(hit), 128'(!e.raw));
         chk("R3 dest idx", 128'(rd), e.raw ? 128'd0 : 128'(w[4:0]));
         chk("R3 src idx",  128'(rs), e.raw ? 128'd0 : 128'(w[9:5]));
         chk({"R9 lanes ", tag(e)}, vec, exp_v);
      end

      // R8 full cap passes everything unchanged
      @(negedge clk);
      insn = mk(1'b1, 2'd1, 6'd15, 5'd1, 5'd1);
      src  = SMIX;
      @(negedge clk);
      chk("R8 passthrough", vec, SMIX);

      // R10 one-cycle latency on back-to-back words
      insn = mk(1'b0, 2'd0, 6'd0, 5'd2, 5'd3);
      src  = SX8;
      @(posedge clk);
      #1;
      insn = mk(1'b1, 2'd2, 6'd31, 5'd4, 5'd5);
      src  = SX32;
      chk("R10 first word", vec, ref_sat(1'b0, 2'd0, 0, SX8));
      @(negedge clk);
      chk("R10 holds until edge", vec, ref_sat(1'b0, 2'd0, 0, SX8));
      @(negedge clk);
      chk("R10 second word", vec, SX32);

      // R10 asynchronous reset mid-run
      rst_n = 1'b0;
      #1;
      chk("R10 async clear hit", 128'(hit), 128'd0);
      chk("R10 async clear vec", vec, 128'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 after release", 128'(rd), 128'd4);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule